// File: doc/BRIEF.md
# Multi-Bus Address Path Steering Controller

This controller drives the seven active-low controls of the address buffers and latches that join a host address bus, a 32-bit latched-address (LA) expansion bus and a 20-bit system-address (SA) expansion bus. Four of the controls are output enables that set the direction of each buffer. Three are latch enables: one captures LA onto the host bus, one captures the host address onto LA, and one captures LA onto SA. The buffers and transceivers themselves are outside this block.

A bus cycle starts when `cyc_start` is sampled with a valid cycle type. It ends when the slave samples `cyc_done` high. While a cycle runs, each buffer enable follows the set of cycle types that may drive through it. Each latch enable opens for one clock at the start of a cycle, and again only at the points listed below. The control is built so that the two buffers facing each other on the same wires are never enabled together. When one cycle follows another directly and the cycle type changes, every enable is released for a gap before the new set is applied.

Cycle type encoding on `cyc_type`: 0 host CPU, 1 DMA, 2 DMA burst, 3 refresh, 4 EISA bus master, 5 ISA bus master. The values 6 and 7 are reserved.

Top module: `asp_steer`

## Requirements
- R1: While reset is asserted, and in every clock with no cycle in progress, all seven controls are high (inactive).
- R2: `hst2la_oe_n` is low during running cycles of type 0, 1, 2 or 3, and high otherwise.
- R3: `la2sa_oe_n` is low during running cycles of type 0, 1, 2, 3 or 4, and high otherwise.
- R4: `la2hst_oe_n` is low during running cycles of type 4 or 5. `sa2la_oe_n` is low only during running cycles of type 5.
- R5: The enables go low in the clock after `cyc_start` is sampled while idle. They stay low until the clock after `cyc_done` is sampled, and then return high.
- R6: `hst_lat_n` is low for one clock, the first clock of a type 4 or type 5 cycle. It then stays high, holding the host address, until the cycle ends.
- R7: `la_lat_n` is low for the first clock of a type 0 cycle only when `pipe_req` was high with its `cyc_start`.
- R8: `sa_lat_n` is low for the first clock of a type 0, 1, 2 or 4 cycle. In a type 2 cycle it is also low for one clock after each clock in which `pipe_req` is sampled high while the cycle continues.
- R9: `hst2la_oe_n` and `la2hst_oe_n` are never low together. `la2sa_oe_n` and `sa2la_oe_n` are never low together.
- R10: Suppose `cyc_done` and `cyc_start` are sampled together. If the type is the same, the enables stay low and the latch pulses of the new cycle's first clock repeat. If the type differs, all controls are high for `GAP_CLKS` clocks and then the new set applies.
- R11: `cyc_start` is ignored while a cycle runs without `cyc_done`, and also during a gap. A start carrying type 6 or 7 starts nothing.
- R12: `cyc_done` sampled while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_type | input | 3 | Cycle type of the cycle being started |
| cyc_start | input | 1 | Cycle start strobe |
| cyc_done | input | 1 | Cycle termination from the slave |
| pipe_req | input | 1 | Burst or address-pipelining indication |
| hst2la_oe_n | output | 1 | Host-to-LA buffer enable, bits 31..2 |
| la2sa_oe_n | output | 1 | LA-to-SA buffer enable, bits 19..2 |
| la2hst_oe_n | output | 1 | LA-to-host buffer enable |
| sa2la_oe_n | output | 1 | SA-to-LA buffer enable, bits 16..2 |
| hst_lat_n | output | 1 | Latch enable, LA onto host bus |
| la_lat_n | output | 1 | Latch enable, host address onto LA |
| sa_lat_n | output | 1 | Latch enable, LA onto SA |

## Verification
The hardest case is a cycle termination and a new cycle start sampled in the same clock. In that clock the controller must either keep its enables and repeat the first-clock latch pulses, or release every driver for the gap. The bench drives these collisions on purpose, with the same type and with opposing types such as host CPU followed by ISA master. It also produces them from random strobes. A behavioural model decides on every clock what each of the seven lines must be, and a separate check confirms that no facing buffers are ever enabled together.

// File: rtl/asp_pkg.sv
package asp_pkg;

    localparam int CT_W = 3;

    typedef enum logic [CT_W-1:0] {
        CY_CPU  = 3'd0,
        CY_DMA  = 3'd1,
        CY_DMAB = 3'd2,
        CY_REF  = 3'd3,
        CY_EISA = 3'd4,
        CY_ISA  = 3'd5,
        CY_RSV6 = 3'd6,
        CY_RSV7 = 3'd7
    } cyc_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_GAP  = 2'd2
    } phase_e;

    // active-low control word, one bit per line
    typedef struct packed {
        logic hst2la;
        logic la2sa;
        logic la2hst;
        logic sa2la;
        logic hst_lat;
        logic la_lat;
        logic sa_lat;
    } ctl_t;

    localparam ctl_t CTL_OFF = '{default: 1'b1};

    function automatic logic type_ok(input logic [CT_W-1:0] t);
        return (t != CY_RSV6) && (t != CY_RSV7);
    endfunction

    function automatic logic drives_la(input cyc_e t);
        return (t == CY_CPU) || (t == CY_DMA) || (t == CY_DMAB) || (t == CY_REF);
    endfunction

    function automatic logic drives_sa(input cyc_e t);
        return drives_la(t) || (t == CY_EISA);
    endfunction

    function automatic logic is_master(input cyc_e t);
        return (t == CY_EISA) || (t == CY_ISA);
    endfunction

    function automatic logic uses_sa_latch(input cyc_e t);
        return (t == CY_CPU) || (t == CY_DMA) || (t == CY_DMAB) || (t == CY_EISA);
    endfunction

endpackage

// File: rtl/asp_seq.sv
module asp_seq
    import asp_pkg::*;
#(
    parameter int GAP_CLKS = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CT_W-1:0]  cyc_type,
    input  logic             cyc_start,
    input  logic             cyc_done,
    input  logic             pipe_req,
    output phase_e           cur_ph,
    output phase_e           nxt_ph,
    output cyc_e             nxt_typ,
    output logic             nxt_first,
    output logic             nxt_piped,
    output logic             nxt_rep
);

    localparam int CNT_W = (GAP_CLKS > 1) ? $clog2(GAP_CLKS) : 1;
    localparam logic [CNT_W-1:0] GAP_LOAD = CNT_W'(GAP_CLKS - 1);

    typedef struct packed {
        phase_e           ph;
        cyc_e             typ;
        logic             first;
        logic             piped;
        logic             rep;
        logic [CNT_W-1:0] cnt;
        cyc_e             pend;
        logic             pend_pipe;
    } seq_t;

    seq_t s_d, s_q;
    logic start_ok;

    assign start_ok = cyc_start && type_ok(cyc_type);

    always_comb begin
        s_d       = s_q;
        s_d.first = 1'b0;
        s_d.rep   = 1'b0;
        case (s_q.ph)
            PH_IDLE: begin
                if (start_ok) begin
                    s_d.ph    = PH_RUN;
                    s_d.typ   = cyc_e'(cyc_type);
                    s_d.first = 1'b1;
                    s_d.piped = pipe_req;
                end
            end
            PH_RUN: begin
                if (cyc_done) begin
                    if (start_ok && (cyc_e'(cyc_type) == s_q.typ)) begin
                        s_d.first = 1'b1;
                        s_d.piped = pipe_req;
                    end else if (start_ok) begin
                        s_d.ph        = PH_GAP;
                        s_d.cnt       = GAP_LOAD;
                        s_d.pend      = cyc_e'(cyc_type);
                        s_d.pend_pipe = pipe_req;
                    end else begin
                        s_d.ph = PH_IDLE;
                    end
                end else if (pipe_req && (s_q.typ == CY_DMAB)) begin
                    s_d.rep = 1'b1;
                end
            end
            PH_GAP: begin
                if (s_q.cnt == '0) begin
                    s_d.ph    = PH_RUN;
                    s_d.typ   = s_q.pend;
                    s_d.first = 1'b1;
                    s_d.piped = s_q.pend_pipe;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, typ: CY_CPU, first: 1'b0, piped: 1'b0, rep: 1'b0,
                     cnt: '0, pend: CY_CPU, pend_pipe: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cur_ph    = s_q.ph;
    assign nxt_ph    = s_d.ph;
    assign nxt_typ   = s_d.typ;
    assign nxt_first = s_d.first;
    assign nxt_piped = s_d.piped;
    assign nxt_rep   = s_d.rep;

    // a running cycle keeps its type until the slave terminates it
    p_run_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_RUN && !cyc_done) |=> (s_q.ph == PH_RUN && $stable(s_q.typ)));

    // idle stays idle unless a valid start arrives
    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_IDLE && !start_ok) |=> (s_q.ph == PH_IDLE));

    // a gap always ends in a running cycle
    p_gap_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_GAP && s_q.cnt == '0) |=> (s_q.ph == PH_RUN && s_q.first));

endmodule

// File: rtl/asp_drive.sv
module asp_drive
    import asp_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_e nxt_ph,
    input  cyc_e   nxt_typ,
    input  logic   nxt_first,
    input  logic   nxt_piped,
    input  logic   nxt_rep,
    output ctl_t   ctl_n
);

    ctl_t out_d, out_q;
    logic run;

    assign run = (nxt_ph == PH_RUN);

    always_comb begin
        out_d         = CTL_OFF;
        out_d.hst2la  = ~(run && drives_la(nxt_typ));
        out_d.la2sa   = ~(run && drives_sa(nxt_typ));
        out_d.la2hst  = ~(run && is_master(nxt_typ));
        out_d.sa2la   = ~(run && (nxt_typ == CY_ISA));
        out_d.hst_lat = ~(run && nxt_first && is_master(nxt_typ));
        out_d.la_lat  = ~(run && nxt_first && nxt_piped && (nxt_typ == CY_CPU));
        out_d.sa_lat  = ~(run && ((nxt_first && uses_sa_latch(nxt_typ)) || nxt_rep));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= CTL_OFF;
        end else begin
            out_q <= out_d;
        end
    end

    assign ctl_n = out_q;

    p_host_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!out_q.hst2la && !out_q.la2hst));

    p_sa_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!out_q.la2sa && !out_q.sa2la));

    // a facing driver is released for at least one clock before the other turns on
    p_host_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_q.hst2la |-> $past(out_q.la2hst));

    p_sa_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_q.sa2la |-> $past(out_q.la2sa));

    p_hlat_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_q.hst_lat |-> !out_q.la2hst);

    p_llat_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_q.la_lat |-> !out_q.hst2la);

    p_slat_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_q.sa_lat |-> !out_q.la2sa);

endmodule

// File: rtl/asp_steer.sv
module asp_steer
    import asp_pkg::*;
#(
    parameter int GAP_CLKS = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] cyc_type,
    input  logic       cyc_start,
    input  logic       cyc_done,
    input  logic       pipe_req,
    output logic       hst2la_oe_n,
    output logic       la2sa_oe_n,
    output logic       la2hst_oe_n,
    output logic       sa2la_oe_n,
    output logic       hst_lat_n,
    output logic       la_lat_n,
    output logic       sa_lat_n
);

    phase_e cur_ph, nxt_ph;
    cyc_e   nxt_typ;
    logic   nxt_first, nxt_piped, nxt_rep;
    ctl_t   ctl_n;

    asp_seq #(.GAP_CLKS(GAP_CLKS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_type  (cyc_type),
        .cyc_start (cyc_start),
        .cyc_done  (cyc_done),
        .pipe_req  (pipe_req),
        .cur_ph    (cur_ph),
        .nxt_ph    (nxt_ph),
        .nxt_typ   (nxt_typ),
        .nxt_first (nxt_first),
        .nxt_piped (nxt_piped),
        .nxt_rep   (nxt_rep)
    );

    asp_drive u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .nxt_ph    (nxt_ph),
        .nxt_typ   (nxt_typ),
        .nxt_first (nxt_first),
        .nxt_piped (nxt_piped),
        .nxt_rep   (nxt_rep),
        .ctl_n     (ctl_n)
    );

    assign hst2la_oe_n = ctl_n.hst2la;
    assign la2sa_oe_n  = ctl_n.la2sa;
    assign la2hst_oe_n = ctl_n.la2hst;
    assign sa2la_oe_n  = ctl_n.sa2la;
    assign hst_lat_n   = ctl_n.hst_lat;
    assign la_lat_n    = ctl_n.la_lat;
    assign sa_lat_n    = ctl_n.sa_lat;

    // no cycle in progress: every line released
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_ph != PH_RUN) |-> (&{hst2la_oe_n, la2sa_oe_n, la2hst_oe_n, sa2la_oe_n,
                                  hst_lat_n, la_lat_n, sa_lat_n}));

endmodule

// File: tb/sim_asp_steer.sv
module sim_asp_steer;

    localparam int CLK_PER  = 10;
    localparam int GAP_CLKS = 1;
    localparam int WD_CYC   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cyc_type = 3'd0;
    logic       cyc_start = 1'b0;
    logic       cyc_done = 1'b0;
    logic       pipe_req = 1'b0;
    logic       hst2la_oe_n, la2sa_oe_n, la2hst_oe_n, sa2la_oe_n;
    logic       hst_lat_n, la_lat_n, sa_lat_n;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    ended = 1'b0;
    string scen = "R1";

    // reference model state
    int m_busy = 0;   // 0 none, 1 running, 2 waiting gap
    int m_kind = 0;
    int m_new  = 0;
    int m_pipe = 0;
    int m_agn  = 0;
    int m_wait = 0;
    int m_nk   = 0;
    int m_np   = 0;

    always #(CLK_PER/2) clk = ~clk;

    asp_steer #(.GAP_CLKS(GAP_CLKS)) u0 (
        .clk(clk), .rst_n(rst_n), .cyc_type(cyc_type), .cyc_start(cyc_start),
        .cyc_done(cyc_done), .pipe_req(pipe_req),
        .hst2la_oe_n(hst2la_oe_n), .la2sa_oe_n(la2sa_oe_n), .la2hst_oe_n(la2hst_oe_n),
        .sa2la_oe_n(sa2la_oe_n), .hst_lat_n(hst_lat_n), .la_lat_n(la_lat_n),
        .sa_lat_n(sa_lat_n)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0; m_new = 0; m_agn = 0; m_wait = 0;
        end else begin
            automatic bit good = cyc_start && (cyc_type < 3'd6);
            automatic int was_new = m_new;
            m_new = 0;
            m_agn = 0;
            if (m_busy == 0) begin
                if (good) begin
                    m_busy = 1; m_kind = cyc_type; m_new = 1; m_pipe = pipe_req;
                end
            end else if (m_busy == 2) begin
                if (m_wait == 0) begin
                    m_busy = 1; m_kind = m_nk; m_new = 1; m_pipe = m_np;
                end else m_wait = m_wait - 1;
            end else begin
                if (!cyc_done) begin
                    if (pipe_req && m_kind == 2) m_agn = 1;
                end else if (!good) m_busy = 0;
                else if (cyc_type == m_kind) begin
                    m_new = 1; m_pipe = pipe_req;
                end else begin
                    m_busy = 2; m_wait = GAP_CLKS - 1; m_nk = cyc_type; m_np = pipe_req;
                end
            end
            if (was_new > 1) m_new = 0;
        end
    end

    task automatic chk(input string req, input string nm, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] %s: got %b expected %b at %0t", req, scen, nm, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!ended) begin
            automatic bit r = (m_busy == 1) && rst_n;
            automatic int k = m_kind;
            chk("R2", "hst2la_oe_n", hst2la_oe_n, !(r && k <= 3));
            chk("R3", "la2sa_oe_n",  la2sa_oe_n,  !(r && k <= 4));
            chk("R4", "la2hst_oe_n", la2hst_oe_n, !(r && (k == 4 || k == 5)));
            chk("R4", "sa2la_oe_n",  sa2la_oe_n,  !(r && k == 5));
            chk("R6", "hst_lat_n",   hst_lat_n,   !(r && m_new == 1 && k >= 4));
            chk("R7", "la_lat_n",    la_lat_n,    !(r && m_new == 1 && k == 0 && m_pipe == 1));
            chk("R8", "sa_lat_n",    sa_lat_n,
                !(r && ((m_new == 1 && k != 3 && k != 5) || m_agn == 1)));
            chk("R9", "facing pairs", (!hst2la_oe_n && !la2hst_oe_n) || (!la2sa_oe_n && !sa2la_oe_n), 1'b0);
        end
    end

    task automatic step(input logic s, input int t, input logic d, input logic p);
        @(negedge clk);
        #1;
        cyc_start = s; cyc_type = 3'(t); cyc_done = d; pipe_req = p;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0);
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        scen = "R1";
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        idle(3);

        scen = "R5";
        for (int t = 0; t < 6; t++) begin
            step(1, t, 0, 1);
            step(0, 0, 0, 0);
            step(0, 0, 0, 0);
            step(0, 0, 1, 0);
            idle(2);
        end

        scen = "R7";
        step(1, 0, 0, 0);
        step(0, 0, 1, 0);
        idle(2);

        scen = "R8";
        step(1, 2, 0, 0);
        step(0, 0, 0, 1);
        step(0, 0, 0, 0);
        step(0, 0, 0, 1);
        step(0, 0, 0, 1);
        step(0, 0, 1, 1);
        idle(2);

        scen = "R10";
        step(1, 1, 0, 0);
        step(0, 0, 1, 0);
        step(1, 1, 1, 0);
        step(0, 0, 1, 0);
        idle(1);
        step(1, 0, 0, 1);
        step(1, 5, 1, 0);
        step(0, 0, 0, 0);
        step(0, 0, 1, 0);
        step(1, 4, 0, 0);
        step(1, 0, 1, 1);
        step(0, 0, 0, 0);
        step(0, 0, 1, 0);
        idle(2);

        scen = "R11";
        step(1, 3, 0, 0);
        step(1, 5, 0, 0);
        step(1, 4, 0, 1);
        step(1, 1, 1, 0);
        step(1, 5, 1, 0);
        step(0, 0, 1, 0);
        idle(1);
        step(1, 6, 0, 0);
        step(1, 7, 0, 1);
        idle(2);

        scen = "R12";
        step(0, 0, 1, 0);
        step(0, 0, 1, 1);
        idle(2);

        scen = "R9";
        for (int i = 0; i < 600; i++) begin
            step($urandom_range(0, 99) < 30, $urandom_range(0, 7),
                 $urandom_range(0, 99) < 25, $urandom_range(0, 99) < 40);
        end
        idle(3);

        scen = "R1";
        #1 rst_n = 1'b0;
        idle(3);
        finish_run();
    end

endmodule